// File: doc/BRIEF.md
# Two-Wire Serial Register Bank Slave

This block is a serial two-wire bus target that runs from a fast system clock. It brings the bus clock and data lines in through synchronizers and tracks bus activity from their edges. It answers one 7-bit device address, which is set on an input port. Behind that address sits a small bank of byte-wide registers, 16 by default, that a bus controller can set up and read back.

After the address byte of a write, the first byte loads an internal register pointer. Any further bytes in the same write land at the pointer. A read returns bytes starting at the pointer. The pointer steps forward after every byte moved in either direction and wraps at the end of the bank. Because the pointer survives a repeated START, a controller can write a register index and then turn the bus round to read from that index without releasing the bus.

The block drives the data line only in open-drain form: `sda_oe` high means "pull the line low". The surrounding pad logic is expected to wire-AND that pull-down with the other bus agents and the pull-up resistor.

Top module: `i2c_rb_slave`

## Requirements
- R1: After reset `sda_oe` is low and every register in the bank reads back as 0x00.
- R2: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. Both are honoured at any point. A STOP returns the block to idle and discards any partial byte. While idle, whole bytes are not acknowledged until a START arrives.
- R3: The first byte after a START is taken MSB first. Bits 7..1 are the device address and bit 0 is the direction (1 = read, 0 = write). The block acknowledges the byte when bits 7..1 equal `dev_addr`.
- R4: On an address mismatch the block does not acknowledge. It leaves the data line alone for every later clock until the next START.
- R5: An acknowledge pulls the data line low after the falling clock edge that ends the eighth bit. The pull-down holds through the whole high phase of the ninth clock and is released after the ninth falling edge.
- R6: In a write, the first byte after the address is the register pointer. A value of `NUM_REGS` or more is not acknowledged, and the pointer keeps its old value.
- R7: Every later byte of a write is stored at the pointer and acknowledged.
- R8: A read returns the register at the pointer, MSB first. Each bit changes only after a falling clock edge and stays stable for the whole high phase that follows.
- R9: The pointer steps by one after each byte written or read, and wraps from `NUM_REGS-1` to 0.
- R10: A repeated START restarts address reception and leaves the pointer unchanged, so a read that follows a pointer write returns that register.
- R11: When the controller does not acknowledge a read byte (data line high in the ninth clock), the block stops transmitting and keeps the data line released until the next START.
- R12: The block never pulls the data line while it is idle or has not been addressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 7 | Device address this block answers to |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High to pull the bus data line low |

## Verification
A wrong internal state shows up at the pad as a misplaced pull-down. Suppose the bit counter or phase slips. The block then acknowledges on the wrong clock or drives a read bit a clock early, and a controller sees the error within the byte in progress. A pointer that is stale, mis-stepped or mis-wrapped gives no sign during a write. It appears only when the register is read back, as a wrong byte on the first data byte of the next read. That is why every write is followed by a read through a repeated START or a fresh transfer.

// File: rtl/i2c_rb_pkg.sv
// Package: shared types for the register-bank bus target.
// Assumes the bus carries 8-bit bytes followed by one acknowledge bit.
package i2c_rb_pkg;

    localparam int BYTE_W = 8;

    // Transfer phase the target is in between bus conditions.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // not addressed, watching for START
        PH_ADDR = 3'd1,   // receiving the address byte
        PH_PTR  = 3'd2,   // receiving the register pointer
        PH_WDAT = 3'd3,   // receiving write data
        PH_RDAT = 3'd4,   // shifting read data out
        PH_RACK = 3'd5    // waiting for the controller's ack of a read byte
    } phase_t;

endpackage

// File: rtl/i2c_rb_sync.sv
// Module: i2c_rb_sync
// Brings LINES asynchronous inputs into the clk domain through STAGES
// flops each, and flags single-cycle rising and falling edges of the
// synchronized level. Assumes the inputs change slowly relative to clk.
module i2c_rb_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES:0] chain;

            // Shift the raw line through the synchronizer plus one history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-1:0], raw_i[g]};
            end

            assign level_o[g] = chain[STAGES-1];
            assign rise_o[g]  =  chain[STAGES-1] & ~chain[STAGES];
            assign fall_o[g]  = ~chain[STAGES-1] &  chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/i2c_rb_regfile.sv
// Module: i2c_rb_regfile
// NUM_REGS byte registers, one write port, one combinational read port.
// Assumes addresses are always inside the map (the caller guarantees it).
module i2c_rb_regfile #(
    parameter int NUM_REGS = 16,
    parameter int AW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] regs [NUM_REGS];

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            // Store the write data when this entry is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)                            regs[g] <= 8'h00;
                else if (we && waddr == AW'(g))        regs[g] <= wdata;
            end
        end
    endgenerate

    assign rdata = regs[raddr];

endmodule

// File: rtl/i2c_rb_slave.sv
// Module: i2c_rb_slave (top)
// Bus target with a register bank. Decodes START and STOP from data-line
// edges while the clock is high. Receives address, pointer and data bytes,
// acknowledges them, and shifts register data out on reads. Assumes clk is
// at least ~10x the bus clock and that the controller never stretches.
module i2c_rb_slave #(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] dev_addr,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    import i2c_rb_pkg::*;

    localparam int            AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [AW-1:0] PTR_MAX = AW'(NUM_REGS - 1);
    localparam logic [8:0]    MAP_LIM = 9'(NUM_REGS);

    logic [1:0] lvl, rse, fll;
    logic       scl_s, sda_s, scl_r, scl_f;
    logic       start_evt, stop_evt;

    phase_t        phase;
    logic [3:0]    cnt;
    logic [7:0]    shreg;
    logic          ack_slot;
    logic          mack;
    logic [AW-1:0] ptr;
    logic [AW-1:0] ptr_step;
    logic          rf_we;
    logic [7:0]    rf_rdata;

    i2c_rb_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .level_o(lvl),
        .rise_o (rse),
        .fall_o (fll)
    );

    assign scl_s     = lvl[0];
    assign sda_s     = lvl[1];
    assign scl_r     = rse[0];
    assign scl_f     = fll[0];
    assign start_evt = fll[1] & scl_s;
    assign stop_evt  = rse[1] & scl_s;

    // Next pointer value, wrapping at the end of the map.
    always_comb ptr_step = (ptr == PTR_MAX) ? '0 : ptr + 1'b1;

    // A write byte is stored when its eighth bit is closed by a falling edge.
    always_comb rf_we = (phase == PH_WDAT) && scl_f && (cnt == 4'd8) && !ack_slot;

    i2c_rb_regfile #(.NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (rf_we),
        .waddr(ptr),
        .wdata(shreg),
        .raddr(ptr),
        .rdata(rf_rdata)
    );

    // Protocol sequencer: bus conditions, bit counting, ack and read drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            ack_slot <= 1'b0;
            mack     <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (start_evt) begin
            phase    <= PH_ADDR;
            cnt      <= '0;
            ack_slot <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (stop_evt) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            ack_slot <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            case (phase)
                PH_ADDR, PH_PTR, PH_WDAT: begin
                    if (scl_r && !ack_slot && cnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end else if (scl_f && !ack_slot && cnt == 4'd8) begin
                        if (phase == PH_ADDR) begin
                            if (shreg[7:1] == dev_addr) begin
                                sda_oe   <= 1'b1;
                                ack_slot <= 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else if (phase == PH_PTR) begin
                            if ({1'b0, shreg} < MAP_LIM) begin
                                ptr      <= shreg[AW-1:0];
                                sda_oe   <= 1'b1;
                                ack_slot <= 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            ptr      <= ptr_step;
                            sda_oe   <= 1'b1;
                            ack_slot <= 1'b1;
                        end
                    end else if (scl_f && ack_slot) begin
                        ack_slot <= 1'b0;
                        cnt      <= '0;
                        if (phase == PH_ADDR && shreg[0]) begin
                            phase  <= PH_RDAT;
                            shreg  <= rf_rdata;
                            sda_oe <= ~rf_rdata[7];
                        end else begin
                            phase  <= (phase == PH_ADDR) ? PH_PTR : PH_WDAT;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                PH_RDAT: begin
                    if (scl_r) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_f) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr_step;
                            phase  <= PH_RACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_r) begin
                        mack <= ~sda_s;
                    end else if (scl_f) begin
                        if (mack) begin
                            phase  <= PH_RDAT;
                            cnt    <= '0;
                            shreg  <= rf_rdata;
                            sda_oe <= ~rf_rdata[7];
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_rb_slave_chk.sv
// Module: i2c_rb_slave_chk
// Property checker bound to i2c_rb_slave. Watches the pad pins and the
// sequencer's phase, pointer and decoded bus conditions.
module i2c_rb_slave_chk #(
    parameter int NUM_REGS = 16,
    parameter int AW       = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input i2c_rb_pkg::phase_t     phase,
    input logic [AW-1:0]          ptr,
    input logic                   start_evt,
    input logic                   stop_evt
);
    import i2c_rb_pkg::*;

    AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));   // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);                 // R12

    AST_PTR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ptr} < (AW + 1)'(NUM_REGS)));            // R9

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> (phase == PH_IDLE && !sda_oe)); // R2

    AST_RESTART_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (phase == PH_ADDR && $stable(ptr))); // R10

endmodule

bind i2c_rb_slave i2c_rb_slave_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .phase    (phase),
    .ptr      (ptr),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
);

// File: tb/i2c_rb_slave_tb.sv
// Directed bench: a bus controller model drives a wired-AND data line and
// checks acknowledges, read data and pointer behaviour per requirement.
module i2c_rb_slave_tb;

    localparam int   CLK_PERIOD = 10;
    localparam int   Q          = 20;          // clk cycles per quarter bus bit
    localparam int   NREG       = 16;
    localparam logic [6:0] MY_ADDR = 7'h52;
    localparam int   WD_CYCLES  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic oe_seen = 1'b0;
    logic done = 1'b0;
    int   checks = 0;
    int   errors = 0;
    logic [7:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_rb_slave #(.NUM_REGS(NREG), .SYNC_STAGES(2)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_addr(MY_ADDR),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe)
    );

    // Sticky record of any pull-down, cleared by the tests that need it.
    always @(negedge clk) if (sda_oe) oe_seen <= 1'b1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
    endtask

    task automatic put_bit(input logic b);
        wq(); sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0;
    endtask

    // Sends a byte; ack is 1 only if the line is low early and late in the 9th high phase.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic early;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        wq(); sda_m = 1'b1; wq(); scl_m = 1'b1;
        repeat (2) @(negedge clk);
        early = ~sda_bus;
        wq(2);
        ack = early & ~sda_bus;
        scl_m = 1'b0;
    endtask

    // Reads a byte and answers with ACK (give_ack=1) or NACK; flags unstable bits.
    task automatic get_byte(input logic give_ack, output logic [7:0] d, output logic unstable);
        logic s1;
        unstable = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(2); scl_m = 1'b1;
            repeat (2) @(negedge clk);
            s1 = sda_bus;
            wq(1);
            d[i] = sda_bus;
            if (s1 != sda_bus) unstable = 1'b1;
            repeat (Q - 2) @(negedge clk);
            scl_m = 1'b0;
        end
        wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
    endtask

    // Sets the pointer with a write, then reads n bytes after a repeated START.
    task automatic read_from(input int p, input int n, input string req);
        logic ack;
        logic [7:0] d;
        logic unst;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'(p), ack);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        chk(req, "read address ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, d, unst);
            chk(req, $sformatf("data at reg %0d", (p + i) % NREG), int'(d), int'(model[(p + i) % NREG]));
            chk("R8", "bit stable while clock high", int'(unst), 0);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1", "sda_oe after reset", int'(sda_oe), 0);
        read_from(0, NREG, "R1");
    endtask

    task automatic t_write_restart();
        logic ack;
        logic [7:0] d;
        logic unst;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack); chk("R3", "write address ack (R5 held)", int'(ack), 1);
        send_byte(8'd3, ack);            chk("R6", "pointer ack", int'(ack), 1);
        send_byte(8'hA5, ack);           chk("R7", "data ack", int'(ack), 1);
        send_byte(8'h3C, ack);           chk("R7", "second data ack", int'(ack), 1);
        model[3] = 8'hA5; model[4] = 8'h3C;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'd3, ack);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack); chk("R10", "read address ack after restart", int'(ack), 1);
        get_byte(1'b1, d, unst); chk("R10", "first read uses written pointer", int'(d), 8'hA5);
        get_byte(1'b0, d, unst); chk("R9", "pointer stepped on read", int'(d), 8'h3C);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic ack;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'(NREG - 1), ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack); chk("R9", "ack after wrap", int'(ack), 1);
        bus_stop();
        model[NREG-1] = 8'h11; model[0] = 8'h22;
        read_from(NREG - 1, 3, "R9");
    endtask

    task automatic t_bad_ptr();
        logic ack;
        logic [7:0] d;
        logic unst;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'd3, ack);
        bus_stop();
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'(NREG + 16), ack); chk("R6", "out-of-map pointer nack", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        get_byte(1'b0, d, unst); chk("R6", "pointer kept after nack", int'(d), int'(model[3]));
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic ack;
        oe_seen = 1'b0;
        bus_start();
        send_byte({MY_ADDR ^ 7'h01, 1'b0}, ack); chk("R4", "foreign address nack", int'(ack), 0);
        send_byte(8'd5, ack);                    chk("R4", "following byte nack", int'(ack), 0);
        send_byte(8'h99, ack);
        bus_stop();
        chk("R12", "no pull-down while unaddressed", int'(oe_seen), 0);
        read_from(5, 1, "R4");
    endtask

    task automatic t_no_start();
        logic ack;
        send_byte({MY_ADDR, 1'b0}, ack); chk("R2", "byte without START not acked", int'(ack), 0);
        send_byte(8'd5, ack);
        bus_stop();
    endtask

    task automatic t_stop_mid();
        logic ack;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'd6, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        wq();
        bus_stop();
        chk("R2", "sda released after STOP", int'(sda_oe), 0);
        read_from(6, 1, "R2");
    endtask

    task automatic t_master_nack();
        logic ack;
        logic [7:0] d;
        logic unst;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'd4, ack);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        get_byte(1'b0, d, unst); chk("R8", "read byte before nack", int'(d), int'(model[4]));
        oe_seen = 1'b0;
        get_byte(1'b0, d, unst);
        chk("R11", "line released after controller nack", int'(d), 8'hFF);
        chk("R11", "no pull-down after nack", int'(oe_seen), 0);
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_restart();
        t_wrap();
        t_bad_ptr();
        t_mismatch();
        t_no_start();
        t_stop_mid();
        t_master_nack();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule